// File: doc/BRIEF.md
# Segmented Fast-Clock Phase Accumulator

This block counts the rising edges of a fast oscillator clock and presents the running count as an 8-bit unsigned word once per rising edge of a much slower reference clock. The word wraps modulo 256. It is the integer phase counter of a digital phase-locked loop. A loop filter reads the word each reference period and takes the difference between consecutive samples as the number of oscillator cycles in that period.

The count is split into two parts. The six high bits come from a binary counter that steps once every four fast cycles. The step is set by a divide-by-four counter that is part of the block. The two low bits are never held in binary form in the fast domain. A four-stage shift register takes the counter's least significant bit as its serial input, so its state walks a Johnson sequence. On each reference edge, registers capture the high bits and the Johnson state together. A decoder behind those registers, in the reference domain, turns the Johnson state into the two low binary bits. The register that feeds the counter's next value is updated only once every four fast cycles, so its adder has four fast cycles to settle. The reference clock is taken to be already retimed onto the fast clock, with its edges falling between fast rising edges.

After reset is released, the sampled word equals the number of fast rising edges seen since the release, minus one, modulo 256.

Top module: `phacc_top`

## Requirements
- R1: While `rst` is high at a reference rising edge, `phase_word` reads 0xFF after that edge.
- R2: At a reference rising edge, `phase_word` equals (n - 1) mod 256. Here n is the number of fast rising edges, with `rst` low, since `rst` was last high. The first sample after reset therefore reads n - 1.
- R3: The low two bits of `phase_word` come from decoding the sampled Johnson state. The low field is (k - 1) mod 4, where k is the number of stages that differ from the oldest stage. Under this rule 1111 and 0000 give 3, 1110 and 0001 give 0, 1100 and 0011 give 1, and 1000 and 0111 give 2. For every fast-cycle phase of the sample, the low field equals (n - 1) mod 4.
- R4: Bits 7:2 of `phase_word` step once every four fast cycles and wrap from 63 to 0. The whole word wraps from 255 to 0 with no missing or repeated value.
- R5: Two consecutive samples differ by the number of fast cycles in the reference period between them, modulo 256.
- R6: `phase_word` changes only after a reference rising edge. Between reference edges it holds its value while the fast clock keeps running.
- R7: Raising `rst` in the middle of a run restarts the count. The samples after the release follow R2 again from n = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Oscillator clock whose rising edges are counted |
| clk_ref | input | 1 | Reference clock, retimed to clk_fast, that samples the count |
| rst | input | 1 | Synchronous active-high reset for both domains |
| phase_word | output | 8 | Sampled count, unsigned, modulo 256 |

## Verification
Two events can land on the same fast cycle: a reference sample, and the step of the upper counter. On that step the Johnson state turns all-equal, and the high field must still show the previous group. The bench provokes this by setting reference periods of 5, 7 and 9 fast cycles, which are coprime to four, so the sample phase rotates through every low-bit value, including the step cycle and the wrap from 255 to 0. Each sample is judged against a plain edge counter kept in the bench, at offset minus one. A period of four is also run; it pins one fixed phase.

// File: rtl/phacc_pkg.sv
package phacc_pkg;

  // Number of stages in the first len bits of v that differ from stage len-1.
  function automatic int unsigned lag_count(input logic [31:0] v, input int unsigned len);
    int unsigned c;
    logic oldest;
    c = 0;
    oldest = v[len-1];
    for (int i = 0; i < 32; i++) begin
      if ((i < int'(len)) && (v[i] != oldest)) c = c + 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/phacc_div.sv
module phacc_div #(
  parameter int LOW_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic step
);
  localparam int DEPTH = 1 << LOW_W;
  localparam logic [LOW_W-1:0] LAST = LOW_W'(DEPTH - 1);

  logic [LOW_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  assign step = (phase_q == LAST);

  // R4
  step_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);

endmodule

// File: rtl/phacc_upper.sv
module phacc_upper #(
  parameter int HI_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  output logic            lsb,
  output logic [HI_W-1:0] hi_aligned
);
  logic [HI_W-1:0] cnt_q;
  logic [HI_W-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  // One fast cycle of lag, matching the lag of the first shift stage.
  always_ff @(posedge clk) begin
    if (rst) dly_q <= '1;
    else     dly_q <= cnt_q;
  end

  assign lsb        = cnt_q[0];
  assign hi_aligned = dly_q;

  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt_q));

  // R4
  upper_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt_q == HI_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/phacc_johnson.sv
module phacc_johnson #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] state
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '1;
    else     sr_q <= {sr_q[DEPTH-2:0], din};
  end

  assign state = sr_q;

  // R3
  johnson_shape_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sr_q[DEPTH-1:1] ^ sr_q[DEPTH-2:0]) <= 1);

endmodule

// File: rtl/phacc_sample.sv
module phacc_sample #(
  parameter int HI_W  = 6,
  parameter int LOW_W = 2,
  localparam int DEPTH = 1 << LOW_W
) (
  input  logic                    clk_ref,
  input  logic                    rst,
  input  logic [HI_W-1:0]         hi_in,
  input  logic [DEPTH-1:0]        jst_in,
  output logic [HI_W+LOW_W-1:0]   word
);
  import phacc_pkg::*;

  logic [HI_W-1:0]  hi_q;
  logic [DEPTH-1:0] jst_q;
  int unsigned      lag;
  logic [LOW_W-1:0] low;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      hi_q  <= '1;
      jst_q <= '1;
    end else begin
      hi_q  <= hi_in;
      jst_q <= jst_in;
    end
  end

  always_comb begin
    lag = lag_count(32'(jst_q), DEPTH);
    low = LOW_W'(lag + DEPTH - 1);
  end

  assign word = {hi_q, low};

  // R1
  reset_word_chk: assert property (@(posedge clk_ref)
    rst |=> (word == '1));

  // R6
  word_hold_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (hi_in == hi_q && jst_in == jst_q) |=> $stable(word));

endmodule

// File: rtl/phacc_top.sv
module phacc_top #(
  parameter int WORD_W = 8,
  parameter int LOW_W  = 2
) (
  input  logic              clk_fast,
  input  logic              clk_ref,
  input  logic              rst,
  output logic [WORD_W-1:0] phase_word
);
  localparam int HI_W  = WORD_W - LOW_W;
  localparam int DEPTH = 1 << LOW_W;

  logic             step;
  logic             up_lsb;
  logic [HI_W-1:0]  hi_al;
  logic [DEPTH-1:0] jst;

  phacc_div #(.LOW_W(LOW_W)) u_div (
    .clk (clk_fast),
    .rst (rst),
    .step(step)
  );

  phacc_upper #(.HI_W(HI_W)) u_upper (
    .clk       (clk_fast),
    .rst       (rst),
    .step      (step),
    .lsb       (up_lsb),
    .hi_aligned(hi_al)
  );

  phacc_johnson #(.DEPTH(DEPTH)) u_jsr (
    .clk  (clk_fast),
    .rst  (rst),
    .din  (up_lsb),
    .state(jst)
  );

  phacc_sample #(.HI_W(HI_W), .LOW_W(LOW_W)) u_smp (
    .clk_ref(clk_ref),
    .rst    (rst),
    .hi_in  (hi_al),
    .jst_in (jst),
    .word   (phase_word)
  );

  // R3
  group_align_chk: assert property (@(posedge clk_fast) disable iff (rst)
    jst[0] == hi_al[0]);

  // R2
  serial_feed_chk: assert property (@(posedge clk_fast) disable iff (rst)
    1'b1 |=> (jst[0] == $past(up_lsb)));

endmodule

// File: tb/test_phacc_top.sv
module test_phacc_top;
  logic       clk_fast = 1'b0;
  logic       clk_ref  = 1'b0;
  logic       rst      = 1'b1;
  logic [7:0] phase_word;
  logic [7:0] n_ref;
  int ref_hi = 3, ref_lo = 4;
  int total = 0, bad = 0;
  bit done = 1'b0;

  phacc_top i_phacc_top (
    .clk_fast  (clk_fast),
    .clk_ref   (clk_ref),
    .rst       (rst),
    .phase_word(phase_word)
  );

  always #4 clk_fast = ~clk_fast;

  // reference clock, edges on fast falling edges
  initial begin
    forever begin
      repeat (ref_lo) @(negedge clk_fast);
      clk_ref = 1'b1;
      repeat (ref_hi) @(negedge clk_fast);
      clk_ref = 1'b0;
    end
  end

  // independent edge counter
  always @(posedge clk_fast) begin
    if (rst) n_ref <= 8'd0;
    else     n_ref <= n_ref + 8'd1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_period(input int p);
    ref_hi = p / 2;
    ref_lo = p - p / 2;
    @(posedge clk_ref);
    @(posedge clk_ref);
  endtask

  task automatic drive_rst(input logic v);
    @(negedge clk_fast);
    #1 rst = v;
  endtask

  task automatic t_reset();
    drive_rst(1'b1);
    repeat (3) begin
      @(posedge clk_ref); #2;
      check("R1 reset word", phase_word, 8'hFF);
    end
    drive_rst(1'b0);
    @(posedge clk_ref); #2;
    check("R2 first sample", phase_word, n_ref - 8'd1);
  endtask

  task automatic t_track(input int p, input int count, input string req);
    set_period(p);
    for (int i = 0; i < count; i++) begin
      @(posedge clk_ref); #2;
      check(req, phase_word, n_ref - 8'd1);
    end
  endtask

  task automatic t_low_phase(input int p);
    set_period(p);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      @(posedge clk_ref); #2;
      e = n_ref - 8'd1;
      check("R3 low field", {6'd0, phase_word[1:0]}, {6'd0, e[1:0]});
    end
  endtask

  task automatic t_wrap(input int p);
    logic [7:0] prev;
    bit seen_wrap = 1'b0;
    set_period(p);
    @(posedge clk_ref); #2;
    prev = phase_word;
    for (int i = 0; i < 70; i++) begin
      @(posedge clk_ref); #2;
      check("R4 upper field", {2'd0, phase_word[7:2]}, {2'd0, n_ref[7:2] - (n_ref[1:0] == 2'd0 ? 6'd1 : 6'd0)});
      check("R5 delta", phase_word - prev, 8'(p));
      if (phase_word < prev) seen_wrap = 1'b1;
      prev = phase_word;
    end
    check("R4 wrap seen", {7'd0, seen_wrap}, 8'd1);
  endtask

  task automatic t_hold(input int p);
    logic [7:0] v;
    set_period(p);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_ref); #2;
      v = phase_word;
      repeat (p - 1) @(negedge clk_fast);
      #2;
      check("R6 hold between edges", phase_word, v);
    end
  endtask

  task automatic t_midreset();
    t_track(7, 5, "R7 before restart");
    drive_rst(1'b1);
    repeat (2) @(posedge clk_ref);
    drive_rst(1'b0);
    @(posedge clk_ref); #2;
    check("R7 restart", phase_word, n_ref - 8'd1);
    t_track(5, 12, "R7 after restart");
  endtask

  initial begin
    t_reset();
    t_track(7, 40, "R2 period 7");
    t_low_phase(7);
    t_low_phase(5);
    t_track(4, 10, "R2 period 4");
    t_wrap(5);
    t_wrap(9);
    t_hold(9);
    t_midreset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule